// File: doc/BRIEF.md
# Prioritized Trap State Machine

This block keeps track of the one processor trap that is waiting to be serviced. It tells the microcode sequencer when the next microinstruction address must be forced to zero. Four trap sources feed it: an init request, a parity-error level, a stack-fault pulse and an instruction-buffer-empty pulse. A clear command from microcode drops the recorded trap. A phase input marks the first cycle of the three-cycle microinstruction. Only two state bits are kept. Parity is not stored as a separate state: it reuses the idle code, and the live parity level tells it apart from idle.

Each cycle the block works out the next trap state from the current state, the trap inputs and the clear command, and registers it. It raises a trap request during the first phase when a trap is pending. It also drives an active-low parity indicator and a signal that forces the control-store bank to zero. The registered state can be read back as the trap type. While init is held, microcode runs the instruction at location zero over and over, and that instruction carries a clear. An inhibit flag, set during init, stops that clear from dropping the init trap before the processor is released.

Top module: `trap_arbiter`

## Requirements
- R1: A synchronous reset sets the registered trap state to idle (code 3) and clears the inhibit flag. With no trap inputs active after reset, trapReq stays low even when phaseOne is high.
- R2: trapType shows the registered state with the codes IB-empty=0, stack=1, init=2, idle=3. nextState is the value that state takes at the next clock edge.
- R3: When several trap inputs are active together, the order from highest to lowest is init, parity, stack, IB-empty. Only one trap is recorded.
- R4: An IB-empty pulse is recorded (code 0) only when the current state is idle. A stack pulse is recorded (code 1) only when the current state is idle or IB-empty. In any other state these pulses leave the state unchanged.
- R5: A parity level moves the state to code 3 unless the current state is init. An init request always moves the state to code 2.
- R6: An accepted clear moves the state to idle. A trap that is accepted in the same cycle overrides the clear.
- R7: trapReq is high exactly when phaseOne is high and either nextState is not 3 or parity is active.
- R8: forceBankZero is high when init is requested, or when trapReq and parity are both active.
- R9: parityLedN is the inverse of the parity level.
- R10: In the init state, clear is ignored while the inhibit flag is set or phaseOne is low. The flag is set in every cycle that init is requested. It is cleared at the end of the first phaseOne cycle in which init is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| initReq | input | 1 | Init trap request (level) |
| parityLevel | input | 1 | Parity-error level |
| stackPulse | input | 1 | Stack-fault trap pulse |
| ibEmptyPulse | input | 1 | Instruction-buffer-empty trap pulse |
| clearCmd | input | 1 | Clear-trap command from microcode |
| phaseOne | input | 1 | High in the first cycle of a microinstruction |
| nextState | output | 2 | State that is loaded at the next edge |
| trapType | output | 2 | Registered trap state, for readback |
| trapReq | output | 1 | Force the next microaddress to zero |
| parityLedN | output | 1 | Parity indicator, active low |
| forceBankZero | output | 1 | Force control-store bank zero |

## Verification
The random stimulus sets each trap source active at its own rate. Init is rare, so pulses, parity and clears get to act on every recorded state, and the priority and state-gating rules are each exercised. Directed sequences cover the following cases:
- Pulses that arrive while a higher trap is held, which separates gating on the current state from plain priority.
- A clear paired with a trap in the same cycle, which shows that the new trap wins.
- A parity level with phaseOne low and then high, which separates the trap request from the bank-forcing signal.
- A full init hold and release with a clear present on every cycle, which shows how long the inhibit flag keeps the init state.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    TS_IBE   = 2'd0,
    TS_STACK = 2'd1,
    TS_INIT  = 2'd2,
    TS_IDLE  = 2'd3
  } trapState_t;

  typedef struct packed {
    logic clearOk;
    logic takeIbe;
    logic takeStack;
    logic takeParity;
    logic takeInit;
  } trapStrobe_t;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        initIn,
  input  logic        parityIn,
  input  logic        stackIn,
  input  logic        ibeIn,
  input  logic        clearIn,
  input  logic        phase1,
  input  trapState_t  curState,
  output trapStrobe_t strobe
);

  logic inhibitQ;
  logic clearBlocked;

  // Inhibit flag: held while init is requested, dropped after the first
  // phase-one cycle without init.
  always_ff @(posedge clk) begin
    if (rst)
      inhibitQ <= 1'b0;
    else if (initIn)
      inhibitQ <= 1'b1;
    else if (phase1)
      inhibitQ <= 1'b0;
  end

  always_comb begin
    clearBlocked      = (curState == TS_INIT) && (inhibitQ || !phase1);
    strobe.clearOk    = clearIn && !clearBlocked;
    strobe.takeIbe    = ibeIn && (curState == TS_IDLE);
    strobe.takeStack  = stackIn && ((curState == TS_IDLE) || (curState == TS_IBE));
    strobe.takeParity = parityIn && (curState != TS_INIT);
    strobe.takeInit   = initIn;
  end

  // R10
  inhibit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == TS_INIT && inhibitQ && !initIn) |=> (curState == TS_INIT));

  // R4
  stack_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (curState == TS_STACK && !initIn && !parityIn && !clearIn) |=> (curState == TS_STACK));

endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  trapStrobe_t strobe,
  input  logic        parityIn,
  input  logic        phase1,
  output trapState_t  curState,
  output trapState_t  nextState,
  output logic        trapReq,
  output logic        forceBank0
);

  trapState_t stateQ;

  // Priority: later assignments win (init > parity > stack > ibe > clear).
  always_comb begin
    nextState = stateQ;
    if (strobe.clearOk)    nextState = TS_IDLE;
    if (strobe.takeIbe)    nextState = TS_IBE;
    if (strobe.takeStack)  nextState = TS_STACK;
    if (strobe.takeParity) nextState = TS_IDLE;
    if (strobe.takeInit)   nextState = TS_INIT;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= TS_IDLE;
    else     stateQ <= nextState;
  end

  assign curState   = stateQ;
  assign trapReq    = phase1 && ((nextState != TS_IDLE) || parityIn);
  assign forceBank0 = strobe.takeInit || (trapReq && parityIn);

  // R5
  init_wins_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.takeInit |=> (stateQ == TS_INIT));

  // R7
  trap_phase_chk: assert property (@(posedge clk) disable iff (rst)
    trapReq |-> phase1);

  // R8
  bank_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (forceBank0 && !strobe.takeInit) |-> (parityIn && phase1));

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       initReq,
  input  logic       parityLevel,
  input  logic       stackPulse,
  input  logic       ibEmptyPulse,
  input  logic       clearCmd,
  input  logic       phaseOne,
  output logic [1:0] nextState,
  output logic [1:0] trapType,
  output logic       trapReq,
  output logic       parityLedN,
  output logic       forceBankZero
);

  trapStrobe_t strobe;
  trapState_t  curState;
  trapState_t  nextSt;

  trap_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .initIn   (initReq),
    .parityIn (parityLevel),
    .stackIn  (stackPulse),
    .ibeIn    (ibEmptyPulse),
    .clearIn  (clearCmd),
    .phase1   (phaseOne),
    .curState (curState),
    .strobe   (strobe)
  );

  trap_state state_i (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .parityIn   (parityLevel),
    .phase1     (phaseOne),
    .curState   (curState),
    .nextState  (nextSt),
    .trapReq    (trapReq),
    .forceBank0 (forceBankZero)
  );

  assign nextState  = nextSt;
  assign trapType   = curState;
  assign parityLedN = ~parityLevel;

endmodule

// File: tb/trap_arbiter_tb.sv
module trap_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, initReq, parityLevel, stackPulse, ibEmptyPulse, clearCmd, phaseOne;
  logic [1:0] nextState, trapType;
  logic trapReq, parityLedN, forceBankZero;

  int nChecks = 0;
  int nFails  = 0;

  logic [1:0] mState;
  logic       mInh;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_arbiter dut_i (
    .clk(clk), .rst(rst), .initReq(initReq), .parityLevel(parityLevel),
    .stackPulse(stackPulse), .ibEmptyPulse(ibEmptyPulse), .clearCmd(clearCmd),
    .phaseOne(phaseOne), .nextState(nextState), .trapType(trapType),
    .trapReq(trapReq), .parityLedN(parityLedN), .forceBankZero(forceBankZero)
  );

  function automatic logic [1:0] modelNext(input logic [1:0] st, input logic inh,
      input logic ini, input logic par, input logic stk, input logic ibe,
      input logic clr, input logic ph);
    logic [1:0] n;
    n = st;
    if (clr && !(st == 2'd2 && (inh || !ph))) n = 2'd3;
    if (ibe && st == 2'd3) n = 2'd0;
    if (stk && (st == 2'd3 || st == 2'd0)) n = 2'd1;
    if (par && st != 2'd2) n = 2'd3;
    if (ini) n = 2'd2;
    return n;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ini, input logic par, input logic stk,
      input logic ibe, input logic clr, input logic ph);
    initReq = ini; parityLevel = par; stackPulse = stk;
    ibEmptyPulse = ibe; clearCmd = clr; phaseOne = ph;
  endtask

  // Checks outputs against the model for the current inputs, then clocks.
  task automatic step();
    logic [1:0] en;
    logic et;
    #(CLK_PERIOD/4);
    en = modelNext(mState, mInh, initReq, parityLevel, stackPulse, ibEmptyPulse, clearCmd, phaseOne);
    et = phaseOne && (en != 2'd3 || parityLevel);
    chk("R2 trapType", trapType, mState);
    chk("R3 R4 R5 R6 R10 nextState", nextState, en);
    chk("R7 trapReq", trapReq, et);
    chk("R8 forceBankZero", forceBankZero, initReq || (et && parityLevel));
    chk("R9 parityLedN", parityLedN, !parityLevel);
    @(posedge clk);
    mState = en;
    if (initReq) mInh = 1'b1;
    else if (phaseOne) mInh = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    nFails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mState = 2'd3; mInh = 1'b0;

    // R1: reset state
    drive(0, 0, 0, 0, 0, 1);
    #1;
    chk("R1 trapType after reset", trapType, 3);
    chk("R1 trapReq after reset", trapReq, 0);
    step();

    // R4: ibe from idle, phase low -> no request
    drive(0, 0, 0, 1, 0, 0);
    #1; chk("R4 ibe from idle", nextState, 0); chk("R7 no req phase low", trapReq, 0);
    step();
    chk("R2 readback ibe code", trapType, 0);
    // R4: stack over ibe
    drive(0, 0, 1, 0, 0, 1);
    #1; chk("R4 stack from ibe", nextState, 1); chk("R7 req phase one", trapReq, 1);
    step();
    // R4: ibe ignored while stack held
    drive(0, 0, 0, 1, 0, 1);
    #1; chk("R4 ibe ignored in stack", nextState, 1);
    step();
    chk("R4 stack kept", trapType, 1);
    // R6: clear
    drive(0, 0, 0, 0, 1, 0);
    #1; chk("R6 clear to idle", nextState, 3);
    step();
    // R6: clear with new stack trap
    drive(0, 0, 1, 0, 1, 0);
    #1; chk("R6 trap beats clear", nextState, 1);
    step();
    // R5/R8/R9: parity from stack, phase low then high
    drive(0, 1, 0, 0, 0, 0);
    #1; chk("R5 parity to 3", nextState, 3); chk("R8 no force phase low", forceBankZero, 0);
    chk("R9 led on", parityLedN, 0);
    step();
    drive(0, 1, 0, 0, 0, 1);
    #1; chk("R7 parity req", trapReq, 1); chk("R8 force with parity", forceBankZero, 1);
    step();
    // R3: all sources together from idle
    drive(0, 1, 1, 1, 0, 0);
    #1; chk("R3 parity above stack", nextState, 3);
    step();
    drive(0, 0, 1, 1, 0, 0);
    #1; chk("R3 stack above ibe", nextState, 1);
    step();
    drive(1, 1, 1, 1, 1, 0);
    #1; chk("R3 init highest", nextState, 2); chk("R8 init forces bank", forceBankZero, 1);
    step();
    // R10: init hold with clear every cycle
    for (int i = 0; i < 3; i++) begin
      drive(1, 0, 0, 0, 1, 1);
      step();
    end
    drive(0, 1, 0, 0, 0, 0);
    #1; chk("R5 parity ignored in init", nextState, 2);
    step();
    drive(0, 0, 0, 0, 1, 1);
    #1; chk("R10 clear blocked by inhibit", nextState, 2);
    step();
    drive(0, 0, 0, 0, 1, 0);
    #1; chk("R10 clear blocked phase low", nextState, 2);
    step();
    drive(0, 0, 0, 0, 1, 1);
    #1; chk("R10 clear accepted", nextState, 3);
    step();

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      drive(($urandom % 16) == 0, ($urandom % 8) == 0, ($urandom % 3) == 0,
            ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0);
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule